// File: doc/BRIEF.md
# Supply-Fail Write-Protect Supervisor

This block guards a battery-backed byte memory against corruption while its main supply comes and goes. It reads three digitized flags from external comparators: supply above the operating minimum, supply below the write-protect threshold, and supply above the battery switchover level. From these it drives a memory access gate, a force that holds the data outputs in high impedance, a battery-select signal and a flag that shows the backup source has been armed.

A new unit leaves reset sealed: the backup source stays disconnected and is never selected. It is armed on the first power-up that clears the protect threshold. After that, a supply decay first blocks access, then hands the memory over to the battery. On restore, the memory goes back to the main supply. Access is allowed again only after a recovery delay, counted in millisecond ticks, has expired with the supply at its operating level. In every state except normal operation the memory interface is held off, so its inputs have no effect.

Top module: `supply_guard`

## Requirements
- R1: After reset the block is sealed: access_en=0, out_hiz=1, bat_sel=0 and bat_armed=0.
- R2: While sealed, bat_sel stays 0 whatever the supply flags and ticks are. The block stays sealed until it samples sup_below_prot=0 together with sup_above_sw=1.
- R3: The first clock edge that samples sup_below_prot=0 with sup_above_sw=1 while sealed sets bat_armed and enters recovery. bat_armed then stays 1 until reset, and the block never returns to the sealed state.
- R4: In normal operation access_en=1 and out_hiz=0. On the edge that samples sup_below_prot=1, the block enters protect, where access_en=0 and out_hiz=1.
- R5: In recovery access_en stays 0 until RECOV_TICKS edges with ms_tick=1 have been counted (the default is 2). The block enters normal operation on the first later edge at which sup_run_ok=1.
- R6: In protect, an edge that samples sup_above_sw=0 enters the battery state, where bat_sel=1. In the battery state, an edge that samples sup_above_sw=1 returns to protect with bat_sel=0.
- R7: In protect, an edge that samples sup_below_prot=0 enters recovery and does not go straight to normal operation.
- R8: If sup_below_prot=1 is sampled during recovery, the tick count restarts from zero. If sup_above_sw=0 is also sampled, the block enters the battery state.
- R9: Once the recovery count is complete, the block waits in recovery with access_en=0 for as long as sup_run_ok=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_run_ok | input | 1 | Supply above the operating minimum |
| sup_below_prot | input | 1 | Supply below the write-protect threshold |
| sup_above_sw | input | 1 | Supply above the battery switchover level |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| access_en | output | 1 | Memory access gate, 1 = chip enable may pass |
| out_hiz | output | 1 | Forces the memory data outputs to high impedance |
| bat_sel | output | 1 | Powers the memory from the backup source |
| bat_armed | output | 1 | Backup source has been connected |

## Verification
Every output is decoded from the state register. A change in the flags or a tick therefore shows at the outputs one clock edge after the edge that samples it, and the recovery release comes one edge after the edge that counts the final tick. The bench drives one set of inputs per cycle on the falling edge and queues the output word expected after the next rising edge. A monitor pops that word half a cycle after the rising edge. The recovery sequences are checked at the cycle just before the expected release, so a count that is off by one, or a count that does not restart, shows up at that cycle.

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int RECOV_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_run_ok,
  input  logic sup_below_prot,
  input  logic sup_above_sw,
  input  logic ms_tick,
  output logic access_en,
  output logic out_hiz,
  output logic bat_sel,
  output logic bat_armed
);
  localparam int CW = $clog2(RECOV_TICKS + 1);
  localparam logic [CW-1:0] CNT_END = CW'(RECOV_TICKS);

  typedef enum logic [2:0] {
    S_SEALED, S_RUN, S_GUARD, S_BATT, S_WAKE
  } state_t;

  state_t st, nxt;
  logic [CW-1:0] cnt;
  logic armed_q;
  logic rec_done;

  assign rec_done = (cnt == CNT_END);

  always_comb begin
    nxt = st;
    unique case (st)
      S_SEALED: if (!sup_below_prot && sup_above_sw) nxt = S_WAKE;
      S_RUN:    if (sup_below_prot) nxt = S_GUARD;
      S_GUARD:  if (!sup_above_sw) nxt = S_BATT;
                else if (!sup_below_prot) nxt = S_WAKE;
      S_BATT:   if (sup_above_sw) nxt = S_GUARD;
      S_WAKE:   if (sup_below_prot) nxt = sup_above_sw ? S_WAKE : S_BATT;
                else if (rec_done && sup_run_ok) nxt = S_RUN;
      default:  nxt = S_SEALED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_SEALED;
      armed_q <= 1'b0;
      cnt     <= '0;
    end else begin
      st <= nxt;
      if (st == S_SEALED && nxt == S_WAKE) armed_q <= 1'b1;
      if (st != S_WAKE || sup_below_prot) cnt <= '0;
      else if (ms_tick && !rec_done) cnt <= cnt + 1'b1;
    end
  end

  assign access_en = (st == S_RUN);
  assign out_hiz   = (st != S_RUN);
  assign bat_sel   = (st == S_BATT);
  assign bat_armed = armed_q;

  p_sealed_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bat_armed |-> !bat_sel);
  p_armed_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bat_armed |=> bat_armed);
  p_drive_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    access_en |-> (!out_hiz && !bat_sel));
  p_dip_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (access_en && sup_below_prot) |=> !access_en);
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_en) |-> ($past(rec_done) && $past(sup_run_ok)));
  p_batt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_sel && !sup_above_sw) |=> bat_sel);
endmodule

// File: tb/supply_guard_tb_top.sv
module supply_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_ok = 1'b0, below = 1'b1, above_sw = 1'b0, tick = 1'b0;
  logic acc, hiz, sel, armed;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  supply_guard #(.RECOV_TICKS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sup_run_ok(run_ok), .sup_below_prot(below),
    .sup_above_sw(above_sw), .ms_tick(tick), .access_en(acc), .out_hiz(hiz),
    .bat_sel(sel), .bat_armed(armed));

  task automatic step(input logic r, input logic b, input logic s, input logic t,
                      input logic [3:0] exp, input string tag);
    @(negedge clk);
    run_ok = r; below = b; above_sw = s; tick = t;
    q.push_back('{exp: exp, tag: tag});
  endtask

  always begin
    @(posedge clk);
    #5;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if ({acc, hiz, sel, armed} !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got acc/hiz/sel/arm=%b expected %b", it.tag,
                 {acc, hiz, sel, armed}, it.exp);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(0, 1, 0, 0, 4'b0100, "R1 reset state");
    step(0, 1, 0, 1, 4'b0100, "R2 sealed no supply no battery");
    step(0, 1, 1, 0, 4'b0100, "R2 sealed above switchover only");
    step(0, 0, 1, 0, 4'b0101, "R3 armed into recovery");
    step(1, 0, 1, 1, 4'b0101, "R5 first tick");
    step(1, 0, 1, 0, 4'b0101, "R5 between ticks");
    step(1, 0, 1, 1, 4'b0101, "R5 last tick counted");
    step(1, 0, 1, 0, 4'b1001, "R5 released to normal");
    step(0, 0, 1, 0, 4'b1001, "R4 normal between thresholds");
    step(0, 1, 1, 0, 4'b0101, "R4 protect on dip");
    step(0, 1, 0, 0, 4'b0111, "R6 switch to battery");
    step(0, 1, 0, 1, 4'b0111, "R6 battery holds");
    step(0, 1, 1, 0, 4'b0101, "R6 back to protect");
    step(0, 0, 1, 0, 4'b0101, "R7 restore enters recovery");
    step(1, 0, 1, 1, 4'b0101, "R8 tick before dip");
    step(1, 1, 1, 0, 4'b0101, "R8 dip during recovery");
    step(1, 0, 1, 1, 4'b0101, "R8 first fresh tick");
    step(1, 0, 1, 1, 4'b0101, "R8 no early release");
    step(1, 0, 1, 0, 4'b1001, "R8 release after restart");
    step(0, 1, 1, 0, 4'b0101, "R4 second dip");
    step(0, 0, 1, 0, 4'b0101, "R7 second restore");
    step(0, 0, 1, 1, 4'b0101, "R9 tick one");
    step(0, 0, 1, 1, 4'b0101, "R9 tick two");
    step(0, 0, 1, 0, 4'b0101, "R9 waits for run level");
    step(0, 0, 1, 0, 4'b0101, "R9 still waiting");
    step(1, 0, 1, 0, 4'b1001, "R9 released at run level");
    step(1, 1, 1, 0, 4'b0101, "R4 third dip");
    step(1, 0, 1, 0, 4'b0101, "R7 third restore");
    step(1, 1, 0, 0, 4'b0111, "R8 recovery to battery");
    step(1, 1, 1, 0, 4'b0101, "R6 battery to protect");
    @(negedge clk);
    rst_n = 1'b0; run_ok = 0; below = 1; above_sw = 0;
    #2;
    n_run++;
    if ({acc, hiz, sel, armed} !== 4'b0100) begin
      n_fail++;
      $display("FAIL R1 reset mid-run: got %b expected 0100", {acc, hiz, sel, armed});
    end
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 1, 0, 0, 4'b0100, "R2 sealed again no battery");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule